// File: doc/BRIEF.md
# Timer Update Event Controller

This block is an up-counting timer core with a programmable prescaler and three double-buffered settings: the wrap (reload) value, the prescale ratio and a compare value. Software writes only the preload copies. The active copies that drive the counter change only when an update event fires. The block decides when that event fires and whether it marks the update interrupt flag.

Three sources can cause an update event: the counter wrapping past its reload value, a one-cycle software update strobe, and a reset/update pulse from an external slave controller. An update-suppress control bit blocks all update events. Even while it is set, the software strobe and the slave pulse still clear the counter and the prescaler. A second control bit limits the interrupt flag to wrap-caused events. Counting runs only while the run bit is set. Software can set that bit, and so can a hardware trigger input.

Top module: `tmr_upd_ctrl`

## Requirements
- R1: After reset, the counter, the three active values, the run bit, the event pulse, the flag and the interrupt output are all 0.
- R2: With run set and active prescale P, the counter advances once every P+1 clock cycles. It goes from 0 up to the active reload value R, then returns to 0, so after n running cycles from a cleared state it reads floor(n/(P+1)) mod (R+1).
- R3: A wrap happens on a counter advance while the counter equals R. When update-suppress is 0, a wrap raises `upd_evt_o` for one cycle and loads the active values from their preloads.
- R4: Writing 1 to bit 0 of the command register (address 5) clears the counter and the prescaler in that cycle. When update-suppress is 0, it also raises an update event and loads the active values.
- R5: A pulse on `slv_rst_i` behaves like the software strobe: it clears the counter and prescaler and, when update-suppress is 0, raises an update event with loading.
- R6: While update-suppress (control bit 1) is 1, no update event fires and the active values hold. The software strobe and `slv_rst_i` still clear the counter, and wraps still return the counter to 0.
- R7: When interrupt-source-limit (control bit 2) is 0, every update event sets the flag. When it is 1, only a wrap-caused event sets the flag.
- R8: The flag is sticky. Writing the status register (address 1) with bit 0 = 0 clears it. Writing it with bit 0 = 1 has no effect.
- R9: `irq_o` is 1 exactly when the flag is set and interrupt-enable (control bit 3) is 1.
- R10: The run bit is control bit 0 at address 0. A pulse on `trig_i` sets it. While the run bit is 0, the counter holds its value.
- R11: Writing the preloads (reload at address 2, prescale at 3, compare at 4) leaves the active values unchanged until the next update event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | DATA_W | Write data |
| slv_rst_i | input | 1 | Slave-controller reset/update pulse |
| trig_i | input | 1 | Hardware trigger; sets the run bit |
| cnt_o | output | CNT_W | Counter value |
| reload_o | output | CNT_W | Active reload value |
| presc_o | output | PSC_W | Active prescale value |
| cmp_o | output | CNT_W | Active compare value |
| upd_evt_o | output | 1 | One-cycle pulse after an update event |
| upd_flag_o | output | 1 | Sticky update flag |
| irq_o | output | 1 | Update interrupt |
| run_o | output | 1 | Run bit |

## Verification
The hardest state to reach is a running counter with update-suppress set, where the counter still wraps and the strobe and slave pulse still clear it, but the active values stay frozen even though a different preload is waiting. The bench first loads a known reload through an ordinary update. It then changes the preload, sets update-suppress while the counter runs, and fires both clearing sources and several natural wraps. Each time it checks that the counter returns to zero with no event pulse and the old reload still active.

// File: rtl/tmr_upd_pkg.sv
package tmr_upd_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_STAT   = 3'd1,
        A_RELOAD = 3'd2,
        A_PRESC  = 3'd3,
        A_CMP    = 3'd4,
        A_CMD    = 3'd5
    } reg_addr_e;

    // control bits, MSB first: irq_en(3) ovf_only(2) upd_off(1) run(0)
    typedef struct packed {
        logic irq_en;
        logic ovf_only;
        logic upd_off;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmr_psc.sv
module tmr_psc #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic         clr_i,
    input  logic [W-1:0] limit_i,
    output logic         tick_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } psc_st_t;

    psc_st_t st_d, st_q;
    logic    at_lim;

    always_comb begin
        st_d   = st_q;
        at_lim = (st_q.cnt == limit_i);
        tick_o = run_i && at_lim;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (run_i) begin
            st_d.cnt = at_lim ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/tmr_shadow.sv
module tmr_shadow #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         load_i,
    output logic [W-1:0] act_o
);

    typedef struct packed {
        logic [W-1:0] pre;
        logic [W-1:0] act;
    } shd_st_t;

    shd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) st_d.act = st_q.pre;
        if (wr_i)   st_d.pre = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign act_o = st_q.act;

endmodule

// File: rtl/tmr_upd_ctrl.sv
module tmr_upd_ctrl
    import tmr_upd_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int DATA_W = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              slv_rst_i,
    input  logic              trig_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic [PSC_W-1:0]  presc_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              upd_evt_o,
    output logic              upd_flag_o,
    output logic              irq_o,
    output logic              run_o
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cnt;
        logic             flag;
        logic             evt;
    } core_st_t;

    core_st_t st_d, st_q;

    logic sw_upd, reinit, tick, ovf, upd;
    logic wr_ctrl, wr_stat, wr_rel, wr_psc, wr_cmp;

    // observation points for the bound checker
    logic upd_off_s, ovf_only_s, run_s, reinit_s, ovf_s;

    always_comb begin
        wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
        wr_stat = wr_en_i && (wr_addr_i == A_STAT);
        wr_rel  = wr_en_i && (wr_addr_i == A_RELOAD);
        wr_psc  = wr_en_i && (wr_addr_i == A_PRESC);
        wr_cmp  = wr_en_i && (wr_addr_i == A_CMP);
        sw_upd  = wr_en_i && (wr_addr_i == A_CMD) && wr_data_i[0];
        reinit  = sw_upd || slv_rst_i;
        ovf     = tick && (st_q.cnt == reload_o) && !reinit;
        upd     = !st_q.ctrl.upd_off && (ovf || reinit);
    end

    tmr_psc #(.W(PSC_W)) i_psc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (st_q.ctrl.run),
        .clr_i   (reinit),
        .limit_i (presc_o),
        .tick_o  (tick)
    );

    tmr_shadow #(.W(CNT_W)) i_shd_rel (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_rel),
        .wdata_i (wr_data_i[CNT_W-1:0]),
        .load_i  (upd),
        .act_o   (reload_o)
    );

    tmr_shadow #(.W(PSC_W)) i_shd_psc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_psc),
        .wdata_i (wr_data_i[PSC_W-1:0]),
        .load_i  (upd),
        .act_o   (presc_o)
    );

    tmr_shadow #(.W(CNT_W)) i_shd_cmp (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_cmp),
        .wdata_i (wr_data_i[CNT_W-1:0]),
        .load_i  (upd),
        .act_o   (cmp_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.evt = upd;

        if (wr_ctrl) st_d.ctrl = ctrl_t'(wr_data_i[CTRL_W-1:0]);
        if (trig_i)  st_d.ctrl.run = 1'b1;

        if (reinit || ovf) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        if (wr_stat && !wr_data_i[0]) st_d.flag = 1'b0;
        if (upd && (!st_q.ctrl.ovf_only || ovf)) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o      = st_q.cnt;
    assign upd_evt_o  = st_q.evt;
    assign upd_flag_o = st_q.flag;
    assign irq_o      = st_q.flag && st_q.ctrl.irq_en;
    assign run_o      = st_q.ctrl.run;

    assign upd_off_s  = st_q.ctrl.upd_off;
    assign ovf_only_s = st_q.ctrl.ovf_only;
    assign run_s      = st_q.ctrl.run;
    assign reinit_s   = reinit;
    assign ovf_s      = ovf;

endmodule

module tmr_upd_chk #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             upd_off_s,
    input logic             ovf_only_s,
    input logic             run_s,
    input logic             reinit_s,
    input logic             ovf_s,
    input logic [CNT_W-1:0] cnt_o,
    input logic [CNT_W-1:0] reload_o,
    input logic [PSC_W-1:0] presc_o,
    input logic [CNT_W-1:0] cmp_o,
    input logic             upd_evt_o,
    input logic             upd_flag_o,
    input logic             irq_o
);

    // R6
    suppressed_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_evt_o |-> !$past(upd_off_s));

    // R11
    active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_evt_o |-> ($stable(reload_o) && $stable(presc_o) && $stable(cmp_o)));

    // R3
    wrap_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(ovf_s) && !$past(upd_off_s)) |-> upd_evt_o);

    // R7
    flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(upd_flag_o) && $past(ovf_only_s)) |-> $past(ovf_s));

    // R10
    stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(run_s) && !$past(reinit_s)) |-> $stable(cnt_o));

    // R9
    irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> upd_flag_o);

endmodule

bind tmr_upd_ctrl tmr_upd_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_off_s  (upd_off_s),
    .ovf_only_s (ovf_only_s),
    .run_s      (run_s),
    .reinit_s   (reinit_s),
    .ovf_s      (ovf_s),
    .cnt_o      (cnt_o),
    .reload_o   (reload_o),
    .presc_o    (presc_o),
    .cmp_o      (cmp_o),
    .upd_evt_o  (upd_evt_o),
    .upd_flag_o (upd_flag_o),
    .irq_o      (irq_o)
);

// File: tb/test_tmr_upd_ctrl.sv
module test_tmr_upd_ctrl;

    localparam int CW = 16;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          slv = 1'b0;
    logic          trig = 1'b0;
    logic [CW-1:0] cnt, rel, cmp;
    logic [PW-1:0] psc;
    logic          evt, flag, irq, run;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    tmr_upd_ctrl #(.CNT_W(CW), .PSC_W(PW)) i_tmr_upd_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .slv_rst_i(slv), .trig_i(trig),
        .cnt_o(cnt), .reload_o(rel), .presc_o(psc), .cmp_o(cmp),
        .upd_evt_o(evt), .upd_flag_o(flag), .irq_o(irq), .run_o(run)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic slv_pulse();
        slv = 1'b1;
        @(negedge clk);
        slv = 1'b0;
    endtask

    task automatic trig_pulse();
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cnt", cnt, 0); chk("R1 reload", rel, 0); chk("R1 presc", psc, 0);
        chk("R1 cmp", cmp, 0); chk("R1 evt", evt, 0); chk("R1 flag", flag, 0);
        chk("R1 irq", irq, 0); chk("R1 run", run, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 preload write does not reach active
        wr(3'd2, 5);
        chk("R11 reload before update", rel, 0);
        // R4 software strobe
        wr(3'd5, 1);
        chk("R4 reload loaded", rel, 5); chk("R4 evt", evt, 1);
        chk("R4 flag", flag, 1); chk("R4 cnt", cnt, 0);
        @(negedge clk);
        chk("R4 evt one cycle", evt, 0);
        // R8 sticky flag
        wr(3'd1, 1);
        chk("R8 write1 no effect", flag, 1);
        wr(3'd1, 0);
        chk("R8 write0 clears", flag, 0);

        // R2 / R3 sweep over prescale and reload
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 5; r++) begin
                wr(3'd0, 0);
                wr(3'd2, CW'(r));
                wr(3'd3, PW'(p));
                wr(3'd5, 1);
                chk("R4 presc loaded", psc, p);
                wr(3'd0, 1);
                for (int n = 1; n <= (p+1)*(r+1)*2 + 3; n++) begin
                    int t;
                    @(negedge clk);
                    t = n / (p+1);
                    chk("R2 count", cnt, t % (r+1));
                    chk("R3 wrap evt", evt,
                        ((n % (p+1)) == 0 && t > 0 && (t % (r+1)) == 0) ? 1 : 0);
                end
            end
        end

        // R3 / R11: preload change applied at wrap
        wr(3'd0, 0);
        wr(3'd2, 3);
        wr(3'd3, 0);
        wr(3'd5, 1);
        wr(3'd0, 1);
        wr(3'd2, 7);
        chk("R2 cnt n1", cnt, 1);
        wr(3'd4, 9);
        chk("R11 reload held", rel, 3);
        @(negedge clk);
        chk("R11 cmp held", cmp, 0); chk("R3 no evt yet", evt, 0);
        @(negedge clk);
        chk("R3 wrap evt", evt, 1); chk("R3 reload loaded", rel, 7);
        chk("R3 cmp loaded", cmp, 9); chk("R3 cnt wrapped", cnt, 0);

        // R6 suppressed updates
        wr(3'd1, 0);
        wr(3'd0, 3);
        repeat (2) @(negedge clk);
        wr(3'd2, 2);
        wr(3'd5, 1);
        chk("R6 sw clears cnt", cnt, 0); chk("R6 sw no evt", evt, 0);
        chk("R6 reload frozen", rel, 7); chk("R6 flag", flag, 0);
        repeat (3) @(negedge clk);
        chk("R6 counting", cnt, 3);
        slv_pulse();
        chk("R6 slv clears cnt", cnt, 0); chk("R6 slv no evt", evt, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R6 wrap no evt", evt, 0);
            chk("R6 reload frozen", rel, 7);
        end
        chk("R6 wrap cnt", cnt, 20 % 8);
        chk("R6 flag stays clear", flag, 0);

        // R5 slave pulse
        wr(3'd0, 1);
        slv_pulse();
        chk("R5 evt", evt, 1); chk("R5 reload loaded", rel, 2);
        chk("R5 cnt", cnt, 0); chk("R5 flag", flag, 1);

        // R7 interrupt source limited to wraps
        wr(3'd1, 0);
        wr(3'd0, 5);
        wr(3'd5, 1);
        chk("R7 sw evt", evt, 1); chk("R7 sw no flag", flag, 0);
        repeat (2) @(negedge clk);
        chk("R7 before wrap", flag, 0);
        @(negedge clk);
        chk("R7 wrap evt", evt, 1); chk("R7 wrap sets flag", flag, 1);

        // R9 interrupt gating
        wr(3'd0, 4);
        chk("R9 flag kept", flag, 1); chk("R9 irq off", irq, 0);
        wr(3'd0, 12);
        chk("R9 irq on", irq, 1);
        wr(3'd1, 0);
        chk("R9 irq after clear", irq, 0);

        // R10 run control
        chk("R10 run cleared", run, 0);
        c = int'(cnt);
        repeat (5) @(negedge clk);
        chk("R10 cnt held", cnt, c);
        trig_pulse();
        chk("R10 trig sets run", run, 1);
        chk("R10 cnt not yet", cnt, c);
        @(negedge clk);
        chk("R10 cnt advances", cnt, (c + 1) % 3);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule